// File: doc/BRIEF.md
# Decimal PIN Key Search Engine

This block tries every six-digit decimal PIN as a cipher key and looks for the PIN that turns an all-zero block into a known first ciphertext word. A decimal counter steps through the candidates in ascending order. Each candidate is written as six ASCII digit characters, and those characters form the key. A key expander turns the key into a table of round keys, one mixing step per cycle. A round engine then encrypts a zero block with that table, one round per cycle. The controller compares the first output half with a 32-bit target that was captured at start.

Software pulses `start` with the target on `target_word`. The engine then works through the candidates from `START_PIN` to `END_PIN` without further help. Every matching candidate produces a one-cycle `hit_valid` pulse, which carries the PIN both as packed BCD and as a binary number, and the search goes on after each hit. When the final candidate has been judged, `busy` falls and `finished` rises. A new `start` begins a fresh sweep. The range bounds are parameters, so a short sub-range can be swept.

Top module: `pin_sweep_engine`

## Requirements
- R1: After reset `busy`, `finished` and `hit_valid` are all low.
- R2: A `start` pulse while `busy` is low captures `target_word`, clears `finished` and raises `busy` on the next clock edge. This also holds when a previous sweep has finished.
- R3: The key for a candidate is six bytes. Byte k is 0x30 plus the k-th decimal digit, counting from the most significant digit, so byte 0 is the hundred-thousands digit. Bytes 0..3 fill key word 0, with byte 0 in bits 31:24. Byte 4 goes to bits 15:8 of key word 1 and byte 5 to bits 7:0.
- R4: The round-key table has 2·ROUNDS+2 words. It starts at 0xB7E15163 and each following word adds 0x9E3779B9. The table is then stirred for 3·(2·ROUNDS+2) steps, each step doing x = rotl(S[i]+x+y, 3), then y = rotl(K[j]+x+y, (x+y) mod 32), writing x back to S[i] and y back to K[j]. The indices i and j wrap at the table size and at the key word count.
- R5: The plaintext is two zero words. The first step adds S[0] and S[1]. Each round r from 1 to ROUNDS then computes a = rotl(a^b, b mod 32)+S[2r] and b = rotl(b^a, a mod 32)+S[2r+1]. Only the final `a` is compared with the target.
- R6: Every candidate whose final `a` equals the captured target gives exactly one single-cycle `hit_valid` pulse, and the sweep continues afterwards.
- R7: Candidates are visited once each, ascending from `START_PIN` to `END_PIN` inclusive, with decimal carries rippling from each digit to the next (…459 is followed by …460).
- R8: After the last candidate `busy` falls and `finished` rises in the same cycle. If that candidate matches, its `hit_valid` pulse appears in that same cycle.
- R9: Every BCD digit of the candidate counter stays in the range 0 to 9.
- R10: During a hit, `hit_pin_bcd` holds the PIN as six 4-bit digits with the most significant digit in bits 23:20, and `hit_pin_bin` holds the same value in binary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a sweep (accepted while not busy) |
| target_word | input | 32 | Expected first ciphertext half, captured on start |
| busy | output | 1 | Sweep in progress |
| finished | output | 1 | Last sweep completed |
| hit_valid | output | 1 | One-cycle pulse for a matching candidate |
| hit_pin_bcd | output | 24 | Matching PIN as packed BCD |
| hit_pin_bin | output | 20 | Matching PIN in binary |

## Verification
The delicate cycle is the one where the last candidate is judged. There a match pulse and the end-of-sweep flag are driven by the same edge. A sweep is therefore run with its target set from an independent software model of the final PIN in the range. The bench samples the outputs once that edge has settled and requires that `hit_valid`, `finished` and the fall of `busy` are seen together, with exactly one hit whose digits and binary value match. Other sweeps put the match on the first candidate, just after a decimal carry, or nowhere, so the cases where a hit and the sweep's end do not coincide are covered as well.

// File: rtl/pin_sweep_pkg.sv
package pin_sweep_pkg;

  localparam int PIN_DIGITS = 6;
  localparam logic [31:0] TABLE_BASE = 32'hB7E15163;
  localparam logic [31:0] TABLE_STEP = 32'h9E3779B9;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_KEY_GO,
    ST_KEY_WAIT,
    ST_ENC_GO,
    ST_ENC_WAIT,
    ST_JUDGE
  } sweep_state_e;

  // left rotate by n through a doubled word
  function automatic logic [31:0] rotl32(input logic [31:0] v, input logic [4:0] n);
    logic [63:0] t;
    t = {v, v} << n;
    return t[63:32];
  endfunction

  function automatic logic [4*PIN_DIGITS-1:0] int_to_bcd(input int val);
    logic [4*PIN_DIGITS-1:0] r;
    int v;
    v = val;
    r = '0;
    for (int d = 0; d < PIN_DIGITS; d++) begin
      r[4*d +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  function automatic logic [19:0] bcd_to_bin(input logic [4*PIN_DIGITS-1:0] bcd);
    logic [19:0] acc;
    acc = '0;
    for (int d = PIN_DIGITS - 1; d >= 0; d--) begin
      acc = 20'(acc * 20'd10) + 20'(bcd[4*d +: 4]);
    end
    return acc;
  endfunction

endpackage

// File: rtl/bcd_sweep_counter.sv
module bcd_sweep_counter #(
  parameter int DIGITS = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [4*DIGITS-1:0]   load_val,
  input  logic                  step,
  output logic [4*DIGITS-1:0]   value
);

  logic [4*DIGITS-1:0] val_q, val_d;
  logic [DIGITS:0]     carry;

  assign carry[0] = step;

  generate
    for (genvar d = 0; d < DIGITS; d++) begin : g_digit
      logic at_nine;
      assign at_nine = (val_q[4*d +: 4] == 4'd9);
      assign carry[d+1] = carry[d] & at_nine;

      always_comb begin
        if (load) begin
          val_d[4*d +: 4] = load_val[4*d +: 4];
        end else if (carry[d]) begin
          val_d[4*d +: 4] = at_nine ? 4'd0 : val_q[4*d +: 4] + 4'd1;
        end else begin
          val_d[4*d +: 4] = val_q[4*d +: 4];
        end
      end

      // R9: digit never leaves 0..9
      assert_digit_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        val_q[4*d +: 4] <= 4'd9);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
    end else if (load || step) begin
      val_q <= val_d;
    end
  end

  assign value = val_q;

endmodule

// File: rtl/key_table_mixer.sv
module key_table_mixer
  import pin_sweep_pkg::*;
#(
  parameter int ROUNDS    = 20,
  parameter int KEY_WORDS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] key_words [KEY_WORDS],
  output logic        done,
  output logic [31:0] sched [2*ROUNDS+2]
);

  localparam int NK    = 2*ROUNDS + 2;
  localparam int STEPS = 3 * ((NK > KEY_WORDS) ? NK : KEY_WORDS);
  localparam int IW    = $clog2(NK);
  localparam int JW    = (KEY_WORDS > 1) ? $clog2(KEY_WORDS) : 1;
  localparam int CW    = $clog2(STEPS + 1);

  logic [31:0]   s_q [NK];
  logic [31:0]   s_d [NK];
  logic [31:0]   l_q [KEY_WORDS];
  logic [31:0]   l_d [KEY_WORDS];
  logic [31:0]   a_q, a_d, b_q, b_d;
  logic [IW-1:0] i_q, i_d;
  logic [JW-1:0] j_q, j_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d, done_q, done_d;
  logic [31:0]   mix_a, mix_sum, mix_b;

  always_comb begin
    s_d    = s_q;
    l_d    = l_q;
    a_d    = a_q;
    b_d    = b_q;
    i_d    = i_q;
    j_d    = j_q;
    cnt_d  = cnt_q;
    run_d  = run_q;
    done_d = 1'b0;
    mix_a   = rotl32(s_q[i_q] + a_q + b_q, 5'd3);
    mix_sum = mix_a + b_q;
    mix_b   = rotl32(l_q[j_q] + mix_sum, mix_sum[4:0]);
    if (start) begin
      for (int k = 0; k < NK; k++) begin
        s_d[k] = TABLE_BASE + TABLE_STEP * 32'(k);
      end
      l_d   = key_words;
      a_d   = '0;
      b_d   = '0;
      i_d   = '0;
      j_d   = '0;
      cnt_d = CW'(STEPS);
      run_d = 1'b1;
    end else if (run_q) begin
      s_d[i_q] = mix_a;
      l_d[j_q] = mix_b;
      a_d      = mix_a;
      b_d      = mix_b;
      i_d      = (i_q == IW'(NK - 1)) ? '0 : i_q + 1'b1;
      j_d      = (j_q == JW'(KEY_WORDS - 1)) ? '0 : j_q + 1'b1;
      cnt_d    = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NK; k++) s_q[k] <= '0;
      for (int k = 0; k < KEY_WORDS; k++) l_q[k] <= '0;
      a_q    <= '0;
      b_q    <= '0;
      i_q    <= '0;
      j_q    <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (start || run_q) begin
        s_q   <= s_d;
        l_q   <= l_d;
        a_q   <= a_d;
        b_q   <= b_d;
        i_q   <= i_d;
        j_q   <= j_d;
        cnt_q <= cnt_d;
        run_q <= run_d;
      end
      done_q <= done_d;
    end
  end

  assign done  = done_q;
  assign sched = s_q;

  // R4: completion is a single pulse
  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R4: step counter stays within the stirring length
  assert_step_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q != '0 && cnt_q <= CW'(STEPS)));

endmodule

// File: rtl/zero_block_rounds.sv
module zero_block_rounds
  import pin_sweep_pkg::*;
#(
  parameter int ROUNDS = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] sched [2*ROUNDS+2],
  output logic        done,
  output logic [31:0] half_a
);

  localparam int NK = 2*ROUNDS + 2;
  localparam int KW = $clog2(NK);
  localparam int RW = $clog2(ROUNDS + 1);

  logic [31:0]   a_q, a_d, b_q, b_d;
  logic [RW-1:0] rnd_q, rnd_d;
  logic          run_q, run_d, done_q, done_d;
  logic [KW-1:0] ka_idx, kb_idx;
  logic [31:0]   r_a, r_b;

  assign ka_idx = KW'(2 * rnd_q);
  assign kb_idx = KW'(2 * rnd_q + 1);
  assign r_a = rotl32(a_q ^ b_q, b_q[4:0]) + sched[ka_idx];
  assign r_b = rotl32(b_q ^ r_a, r_a[4:0]) + sched[kb_idx];

  always_comb begin
    a_d    = a_q;
    b_d    = b_q;
    rnd_d  = rnd_q;
    run_d  = run_q;
    done_d = 1'b0;
    if (start) begin
      a_d   = sched[0];
      b_d   = sched[1];
      rnd_d = RW'(1);
      run_d = 1'b1;
    end else if (run_q) begin
      a_d = r_a;
      b_d = r_b;
      if (rnd_q == RW'(ROUNDS)) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end else begin
        rnd_d = rnd_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      rnd_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (start || run_q) begin
        a_q   <= a_d;
        b_q   <= b_d;
        rnd_q <= rnd_d;
        run_q <= run_d;
      end
      done_q <= done_d;
    end
  end

  assign done   = done_q;
  assign half_a = a_q;

  // R5: the round index stays within 1..ROUNDS while running
  assert_round_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (rnd_q >= RW'(1) && rnd_q <= RW'(ROUNDS)));
  // R5: the output word holds still once done is reported
  assert_result_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !start) |=> $stable(a_q));

endmodule

// File: rtl/pin_sweep_engine.sv
module pin_sweep_engine
  import pin_sweep_pkg::*;
#(
  parameter int ROUNDS    = 20,
  parameter int START_PIN = 0,
  parameter int END_PIN   = 999999
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] target_word,
  output logic        busy,
  output logic        finished,
  output logic        hit_valid,
  output logic [23:0] hit_pin_bcd,
  output logic [19:0] hit_pin_bin
);

  localparam int NK        = 2*ROUNDS + 2;
  localparam int KEY_WORDS = (PIN_DIGITS + 3) / 4;
  localparam int BCD_W     = 4 * PIN_DIGITS;
  localparam logic [BCD_W-1:0] START_BCD = int_to_bcd(START_PIN);
  localparam logic [BCD_W-1:0] END_BCD   = int_to_bcd(END_PIN);

  // reset: asserted at once, released through two flops
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  sweep_state_e      state_q, state_d;
  logic              busy_q, busy_d, fin_q, fin_d, hit_q, hit_d;
  logic [31:0]       target_q, target_d;
  logic [19:0]       bin_q, bin_d;
  logic [BCD_W-1:0]  hit_bcd_q, hit_bcd_d;
  logic [19:0]       hit_bin_q, hit_bin_d;
  logic              cnt_load, cnt_step, key_go, enc_go;
  logic [BCD_W-1:0]  pin_bcd;
  logic [7:0]        key_bytes [PIN_DIGITS];
  logic [31:0]       key_words [KEY_WORDS];
  logic [31:0]       sched [NK];
  logic              key_done, enc_done;
  logic [31:0]       enc_half;

  bcd_sweep_counter #(.DIGITS(PIN_DIGITS)) u_count (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .load     (cnt_load),
    .load_val (START_BCD),
    .step     (cnt_step),
    .value    (pin_bcd)
  );

  // ASCII digit bytes, most significant digit first
  generate
    for (genvar b = 0; b < PIN_DIGITS; b++) begin : g_byte
      assign key_bytes[b] = {4'h3, pin_bcd[4*(PIN_DIGITS-1-b) +: 4]};
    end
  endgenerate

  always_comb begin
    for (int w = 0; w < KEY_WORDS; w++) key_words[w] = '0;
    for (int b = 0; b < PIN_DIGITS; b++) begin
      key_words[b/4] = {key_words[b/4][23:0], key_bytes[b]};
    end
  end

  key_table_mixer #(.ROUNDS(ROUNDS), .KEY_WORDS(KEY_WORDS)) u_keys (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .start     (key_go),
    .key_words (key_words),
    .done      (key_done),
    .sched     (sched)
  );

  zero_block_rounds #(.ROUNDS(ROUNDS)) u_rounds (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .start  (enc_go),
    .sched  (sched),
    .done   (enc_done),
    .half_a (enc_half)
  );

  always_comb begin
    state_d   = state_q;
    busy_d    = busy_q;
    fin_d     = fin_q;
    target_d  = target_q;
    bin_d     = bin_q;
    hit_d     = 1'b0;
    hit_bcd_d = hit_bcd_q;
    hit_bin_d = hit_bin_q;
    cnt_load  = 1'b0;
    cnt_step  = 1'b0;
    key_go    = 1'b0;
    enc_go    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          target_d = target_word;
          cnt_load = 1'b1;
          bin_d    = 20'(START_PIN);
          busy_d   = 1'b1;
          fin_d    = 1'b0;
          state_d  = ST_KEY_GO;
        end
      end
      ST_KEY_GO: begin
        key_go  = 1'b1;
        state_d = ST_KEY_WAIT;
      end
      ST_KEY_WAIT: if (key_done) state_d = ST_ENC_GO;
      ST_ENC_GO: begin
        enc_go  = 1'b1;
        state_d = ST_ENC_WAIT;
      end
      ST_ENC_WAIT: if (enc_done) state_d = ST_JUDGE;
      ST_JUDGE: begin
        if (enc_half == target_q) begin
          hit_d     = 1'b1;
          hit_bcd_d = pin_bcd;
          hit_bin_d = bin_q;
        end
        if (pin_bcd == END_BCD) begin
          busy_d  = 1'b0;
          fin_d   = 1'b1;
          state_d = ST_IDLE;
        end else begin
          cnt_step = 1'b1;
          bin_d    = bin_q + 20'd1;
          state_d  = ST_KEY_GO;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      state_q   <= ST_IDLE;
      busy_q    <= 1'b0;
      fin_q     <= 1'b0;
      hit_q     <= 1'b0;
      target_q  <= '0;
      bin_q     <= '0;
      hit_bcd_q <= '0;
      hit_bin_q <= '0;
    end else begin
      state_q <= state_d;
      busy_q  <= busy_d;
      fin_q   <= fin_d;
      hit_q   <= hit_d;
      if (state_q == ST_IDLE && start) target_q <= target_d;
      if (cnt_load || cnt_step) bin_q <= bin_d;
      if (hit_d) begin
        hit_bcd_q <= hit_bcd_d;
        hit_bin_q <= hit_bin_d;
      end
    end
  end

  assign busy        = busy_q;
  assign finished    = fin_q;
  assign hit_valid   = hit_q;
  assign hit_pin_bcd = hit_bcd_q;
  assign hit_pin_bin = hit_bin_q;

  // R2: an accepted start raises busy on the next edge
  assert_start_launch_R2: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (start && !busy_q) |=> busy_q);
  // R8: finished and busy are never high together
  assert_fin_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_sync_q)
    fin_q |-> !busy_q);
  // R6: a hit only follows a cycle spent sweeping
  assert_hit_in_sweep_R6: assert property (@(posedge clk) disable iff (!rst_sync_q)
    hit_q |-> $past(busy_q));
  // R10: reported binary value agrees with the reported digits
  assert_bin_tracks_bcd_R10: assert property (@(posedge clk) disable iff (!rst_sync_q)
    hit_q |-> (hit_bin_q == bcd_to_bin(hit_bcd_q)));
  // R7: the binary candidate stays inside the configured range
  assert_range_R7: assert property (@(posedge clk) disable iff (!rst_sync_q)
    busy_q |-> (int'(bin_q) >= START_PIN && int'(bin_q) <= END_PIN));

endmodule

// File: tb/sim_pin_sweep_engine.sv
`timescale 1ns/1ps
module sim_pin_sweep_engine;

  localparam int NR    = 20;
  localparam int FIRST = 123457;
  localparam int LAST  = 123462;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] target_word;
  logic        busy, finished, hit_valid;
  logic [23:0] hit_pin_bcd;
  logic [19:0] hit_pin_bin;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;
  bit ended    = 0;

  always #2.5 clk = ~clk;

  pin_sweep_engine #(.ROUNDS(NR), .START_PIN(FIRST), .END_PIN(LAST)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .target_word(target_word),
    .busy(busy), .finished(finished), .hit_valid(hit_valid),
    .hit_pin_bcd(hit_pin_bcd), .hit_pin_bin(hit_pin_bin)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !ended) begin
      n_fails = n_fails + 1;
      $display("FAIL watchdog: run hung, actual cycle %0d expected end before it", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks = n_checks + 1;
    if (!ok) begin
      n_fails = n_fails + 1;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rl(input logic [31:0] v, input logic [31:0] n);
    int s;
    s = int'(n & 32'd31);
    if (s == 0) return v;
    return (v << s) | (v >> (32 - s));
  endfunction

  // independent software model: first ciphertext half for a PIN
  function automatic logic [31:0] ref_half(input int pin);
    logic [7:0]  kb [6];
    logic [31:0] kw [2];
    logic [31:0] s [2*NR+2];
    logic [31:0] a, b;
    int v, i, j;
    v = pin;
    for (int d = 5; d >= 0; d--) begin
      kb[d] = 8'h30 + 8'(v % 10);
      v = v / 10;
    end
    kw[0] = 0; kw[1] = 0;
    for (int k = 0; k < 6; k++) kw[k/4] = (kw[k/4] << 8) + 32'(kb[k]);
    s[0] = 32'hB7E15163;
    for (int k = 1; k < 2*NR+2; k++) s[k] = s[k-1] + 32'h9E3779B9;
    a = 0; b = 0; i = 0; j = 0;
    for (int k = 0; k < 3*(2*NR+2); k++) begin
      a = rl(s[i] + a + b, 3);
      s[i] = a;
      b = rl(kw[j] + a + b, a + b);
      kw[j] = b;
      i = (i + 1) % (2*NR+2);
      j = (j + 1) % 2;
    end
    a = s[0]; b = s[1];
    for (int r = 1; r <= NR; r++) begin
      a = rl(a ^ b, b) + s[2*r];
      b = rl(b ^ a, a) + s[2*r+1];
    end
    return a;
  endfunction

  function automatic logic [23:0] to_bcd(input int pin);
    logic [23:0] r;
    int v;
    v = pin;
    for (int d = 0; d < 6; d++) begin
      r[4*d +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  int          got_hits;
  logic [23:0] got_bcd;
  logic [19:0] got_bin;
  bit          got_fin_with_hit;

  // drives one sweep and records the hits seen
  task automatic sweep(input logic [31:0] tgt);
    int n;
    got_hits = 0; got_bcd = '0; got_bin = '0; got_fin_with_hit = 0;
    @(negedge clk);
    target_word = tgt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
    chk(finished == 1'b0, "R2 finished cleared", finished, 0);
    n = 0;
    while (!finished && n < 20000) begin
      @(negedge clk);
      n++;
      if (hit_valid) begin
        got_hits++;
        got_bcd = hit_pin_bcd;
        got_bin = hit_pin_bin;
        got_fin_with_hit = finished;
      end
    end
    chk(finished == 1'b1 && busy == 1'b0, "R8 sweep ended", {finished, busy}, 2'b10);
  endtask

  task automatic test_reset();
    chk(busy == 1'b0, "R1 busy reset", busy, 0);
    chk(finished == 1'b0, "R1 finished reset", finished, 0);
    chk(hit_valid == 1'b0, "R1 hit_valid reset", hit_valid, 0);
  endtask

  task automatic test_hit_on(input int pin, input string tag);
    sweep(ref_half(pin));
    chk(got_hits == 1, {tag, " R6 hit count"}, got_hits, 1);
    chk(got_bcd == to_bcd(pin), {tag, " R3 R10 hit digits"}, got_bcd, to_bcd(pin));
    chk(got_bin == 20'(pin), {tag, " R10 hit binary"}, got_bin, pin);
  endtask

  task automatic test_first();
    test_hit_on(FIRST, "first R7");
    chk(got_fin_with_hit == 1'b0, "R6 search continued past hit", got_fin_with_hit, 0);
  endtask

  task automatic test_after_carry();
    test_hit_on(123460, "carry R7");
  endtask

  task automatic test_last_coincide();
    test_hit_on(LAST, "last R8");
    chk(got_fin_with_hit == 1'b1, "R8 hit and finished same cycle", got_fin_with_hit, 1);
  endtask

  task automatic test_no_match();
    logic [31:0] t;
    bit clash;
    t = ref_half(FIRST) + 32'd1;
    do begin
      clash = 0;
      for (int p = FIRST; p <= LAST; p++) if (ref_half(p) == t) clash = 1;
      if (clash) t = t + 32'd1;
    end while (clash);
    sweep(t);
    chk(got_hits == 0, "R5 R6 no hit for foreign target", got_hits, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    target_word = '0;
    repeat (4) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    test_reset();
    test_first();
    test_after_carry();
    test_last_coincide();
    test_no_match();
    ended = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule